// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This unit sits between a processor's address stage and its register write port for load operations. From a base register value and a signed 16-bit offset it forms the byte address sent to a 32-bit, little-endian, word-wide data memory. It takes the word that memory returns and picks out the byte or halfword lane that the low address bits select. It then sign- or zero-extends that lane to 32 bits and registers the result for write-back.

One datapath covers signed and unsigned byte loads, signed and unsigned halfword loads, full word loads, and the upper-immediate load. The upper-immediate load builds its result from the offset field alone and issues no memory read. Halfword and word accesses that break their natural alignment raise a flag, suppress the read strobe and return zero.

The address and read strobe are combinational from the request. The formatted result, the misalignment flag and a valid bit are registered one clock after the request is accepted.

Top module: `ld_format_unit`

## Requirements
- R1: `addr` equals `base` plus the 16-bit `imm` sign-extended to 32 bits, modulo 2^32, in the same cycle as the request and for every `kind`.
- R2: `kind` 0 (signed byte) and 1 (unsigned byte) select byte `addr[1:0]` of `rdata`, where lane 0 is bits 7:0 and lane 3 is bits 31:24. Kind 0 copies bit 7 of that byte into bits 31:8. Kind 1 clears bits 31:8.
- R3: `kind` 2 (signed halfword) and 3 (unsigned halfword) select `rdata[15:0]` when `addr[1]` is 0 and `rdata[31:16]` when it is 1. Kind 2 sign-extends the halfword and kind 3 zero-extends it.
- R4: `kind` 4 (word) returns `rdata` unchanged when `addr[1:0]` is 0. Otherwise it is misaligned.
- R5: `kind` 5 (upper immediate) returns `{imm, 16'h0000}`, never flags misalignment and keeps `rd_en` low.
- R6: A halfword load with `addr[0]` = 1, or a word load with `addr[1:0]` nonzero, sets `misal_q`, returns a zero `result_q` and keeps `rd_en` low.
- R7: `rd_en` is high only when `en` is high, `kind` is 0 to 4 and the access is aligned. `result_q` and `misal_q` load one clock after a cycle with `en` high. `vld_q` is `en` delayed by one clock. While `en` is low, `result_q` and `misal_q` hold their values.
- R8: `kind` 6 and 7 are reserved. They give a zero result, no misalignment and no read.
- R9: While `rst_n` is low, `result_q`, `misal_q` and `vld_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load request this cycle |
| kind | input | 3 | Load kind code (see R2 to R8) |
| base | input | 32 | Base register value |
| imm | input | 16 | Signed offset, or the upper-immediate value |
| rdata | input | 32 | Word returned by memory for the current address |
| addr | output | 32 | Effective byte address |
| rd_en | output | 1 | Memory read strobe |
| result_q | output | 32 | Formatted load result |
| misal_q | output | 1 | Misalignment flag for the registered result |
| vld_q | output | 1 | Registered result is from a request |

## Verification
A single memory word with distinct bytes, and with both set and clear sign bits in different lanes, is read at every byte offset. This shows whether the right lane was chosen and whether sign fill differs from zero fill. Halfword patterns at offsets 0 and 2 separate the lower and upper halves. Odd offsets, and word offsets 1 to 3, separate legal accesses from flagged ones. A negative offset, a carry that wraps the address through zero, the upper-immediate kind with a nonzero base and the reserved codes exercise the adder and the paths that issue no read. A cycle with the request low after a load shows that the registered result holds.

// File: rtl/ld_format_pkg.sv
package ld_format_pkg;
  typedef enum logic [2:0] {
    LK_SBYTE = 3'd0,
    LK_UBYTE = 3'd1,
    LK_SHALF = 3'd2,
    LK_UHALF = 3'd3,
    LK_WORD  = 3'd4,
    LK_UPIMM = 3'd5,
    LK_RSV6  = 3'd6,
    LK_RSV7  = 3'd7
  } ld_kind_e;

  function automatic logic is_mem_kind(input ld_kind_e k);
    return (k == LK_SBYTE) || (k == LK_UBYTE) || (k == LK_SHALF) ||
           (k == LK_UHALF) || (k == LK_WORD);
  endfunction
endpackage

// File: rtl/ld_rst_sync.sv
module ld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/ld_agen.sv
module ld_agen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_sx;

  always_comb begin
    imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    addr   = base + imm_sx;
  end
endmodule

// File: rtl/ld_align_chk.sv
module ld_align_chk
  import ld_format_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  ld_kind_e          kind,
  input  logic [LANE_W-1:0] offs,
  output logic              misal
);
  always_comb begin
    unique case (kind)
      LK_SHALF, LK_UHALF: misal = offs[0];
      LK_WORD:            misal = |offs;
      default:            misal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ld_lane_fmt.sv
module ld_lane_fmt
  import ld_format_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  ld_kind_e                      kind,
  input  logic [$clog2(DATA_W/8)-1:0]   offs,
  input  logic [DATA_W-1:0]             rdata,
  input  logic [IMM_W-1:0]              imm,
  output logic [DATA_W-1:0]             fmt
);
  localparam int NBYTES = DATA_W / 8;
  localparam int NHALF  = DATA_W / 16;
  localparam int LANE_W = $clog2(NBYTES);

  logic [7:0]  byte_ln [NBYTES];
  logic [15:0] half_ln [NHALF];

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      assign byte_ln[g] = rdata[8*g +: 8];
    end
    for (g = 0; g < NHALF; g++) begin : g_half
      assign half_ln[g] = rdata[16*g +: 16];
    end
  endgenerate

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = byte_ln[offs];
    sel_h = half_ln[offs[LANE_W-1:1]];
    unique case (kind)
      LK_SBYTE: fmt = {{(DATA_W-8){sel_b[7]}}, sel_b};
      LK_UBYTE: fmt = {{(DATA_W-8){1'b0}}, sel_b};
      LK_SHALF: fmt = {{(DATA_W-16){sel_h[15]}}, sel_h};
      LK_UHALF: fmt = {{(DATA_W-16){1'b0}}, sel_h};
      LK_WORD:  fmt = rdata;
      LK_UPIMM: fmt = {imm, {(DATA_W-IMM_W){1'b0}}};
      default:  fmt = '0;
    endcase
  end
endmodule

// File: rtl/ld_format_unit.sv
module ld_format_unit
  import ld_format_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic [DATA_W-1:0] result_q,
  output logic              misal_q,
  output logic              vld_q
);
  localparam int LANE_W = $clog2(DATA_W / 8);

  logic              rst_sync_n;
  ld_kind_e          kind_e;
  logic              misal;
  logic [DATA_W-1:0] fmt;
  logic [DATA_W-1:0] result_d;
  logic              misal_d;
  logic              vld_d;

  assign kind_e = ld_kind_e'(kind);

  ld_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ld_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .base (base),
    .imm  (imm),
    .addr (addr)
  );

  ld_align_chk #(.LANE_W(LANE_W)) u_align (
    .kind  (kind_e),
    .offs  (addr[LANE_W-1:0]),
    .misal (misal)
  );

  ld_lane_fmt #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_lane (
    .kind  (kind_e),
    .offs  (addr[LANE_W-1:0]),
    .rdata (rdata),
    .imm   (imm),
    .fmt   (fmt)
  );

  // Read strobe: a memory kind that is aligned and requested.
  assign rd_en = en && is_mem_kind(kind_e) && !misal;

  // Next-state logic with explicit clock enable.
  always_comb begin
    result_d = result_q;
    misal_d  = misal_q;
    vld_d    = en;
    if (en) begin
      result_d = misal ? '0 : fmt;
      misal_d  = misal;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
      misal_q  <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      result_q <= result_d;
      misal_q  <= misal_d;
      vld_q    <= vld_d;
    end
  end
endmodule

// File: rtl/ld_format_sva.sv
module ld_format_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [2:0]  kind,
  input logic [31:0] addr,
  input logic        rd_en,
  input logic [31:0] result_q,
  input logic        misal_q,
  input logic        vld_q
);
  a_r5_upimm_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == 3'd5) |-> !rd_en);

  a_r6_misal_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && misal_q) |-> (result_q == 32'h0));

  a_r6_odd_half_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (kind == 3'd2 || kind == 3'd3) && addr[0]) |=> misal_q);

  a_r2_ubyte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == 3'd1) |=> (result_q[31:8] == 24'h0));

  a_r7_vld_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> vld_q);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result_q) && $stable(misal_q)));

  a_r8_reserved_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind[2:1] == 2'b11) |-> !rd_en);
endmodule

bind ld_format_unit ld_format_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en       (en),
  .kind     (kind),
  .addr     (addr),
  .rd_en    (rd_en),
  .result_q (result_q),
  .misal_q  (misal_q),
  .vld_q    (vld_q)
);

// File: tb/test_ld_format_unit.sv
module test_ld_format_unit;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [2:0]  kind;
  logic [31:0] base;
  logic [15:0] imm;
  logic [31:0] rdata;
  logic [31:0] addr;
  logic        rd_en;
  logic [31:0] result_q;
  logic        misal_q;
  logic        vld_q;

  int n_chk;
  int n_bad;

  localparam logic [31:0] MEMW = 32'hF172_8435;

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] base;
    logic [15:0] imm;
    logic [31:0] e_addr;
    logic [31:0] e_res;
    logic        e_mis;
    logic        e_rd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_1000, 16'h0000, 32'h0000_1000, 32'h0000_0035, 1'b0, 1'b1}, // R2 lane 0
    '{3'd0, 32'h0000_1000, 16'h0001, 32'h0000_1001, 32'hFFFF_FF84, 1'b0, 1'b1}, // R2 sign fill
    '{3'd1, 32'h0000_1000, 16'h0001, 32'h0000_1001, 32'h0000_0084, 1'b0, 1'b1}, // R2 zero fill
    '{3'd0, 32'h0000_1003, 16'h0000, 32'h0000_1003, 32'hFFFF_FFF1, 1'b0, 1'b1}, // R2 lane 3
    '{3'd1, 32'h0000_1002, 16'h0000, 32'h0000_1002, 32'h0000_0072, 1'b0, 1'b1}, // R2 lane 2
    '{3'd2, 32'h0000_2000, 16'h0002, 32'h0000_2002, 32'hFFFF_F172, 1'b0, 1'b1}, // R3 upper half
    '{3'd3, 32'h0000_2000, 16'h0002, 32'h0000_2002, 32'h0000_F172, 1'b0, 1'b1}, // R3 upper zero
    '{3'd2, 32'h0000_2000, 16'h0000, 32'h0000_2000, 32'hFFFF_8435, 1'b0, 1'b1}, // R3 lower half
    '{3'd3, 32'h0000_2000, 16'h0000, 32'h0000_2000, 32'h0000_8435, 1'b0, 1'b1}, // R3 lower zero
    '{3'd2, 32'h0000_2000, 16'h0003, 32'h0000_2003, 32'h0000_0000, 1'b1, 1'b0}, // R6 odd half
    '{3'd4, 32'h0000_3000, 16'hFFFC, 32'h0000_2FFC, 32'hF172_8435, 1'b0, 1'b1}, // R4 R1 negative offset
    '{3'd4, 32'h0000_3000, 16'h0002, 32'h0000_3002, 32'h0000_0000, 1'b1, 1'b0}, // R4 R6 misaligned word
    '{3'd5, 32'h0000_0055, 16'hBEEF, 32'hFFFF_BF44, 32'hBEEF_0000, 1'b0, 1'b0}, // R5 upper immediate
    '{3'd6, 32'h0000_0000, 16'h0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}, // R8 reserved
    '{3'd0, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0000, 32'h0000_0035, 1'b0, 1'b1}, // R1 wrap
    '{3'd3, 32'h0000_0010, 16'h8001, 32'hFFFF_8011, 32'h0000_0000, 1'b1, 1'b0}  // R6 odd unsigned half
  };

  ld_format_unit i_ld_format_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .kind     (kind),
    .base     (base),
    .imm      (imm),
    .rdata    (rdata),
    .addr     (addr),
    .rd_en    (rd_en),
    .result_q (result_q),
    .misal_q  (misal_q),
    .vld_q    (vld_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    en    = 1'b0;
    kind  = 3'd0;
    base  = '0;
    imm   = '0;
    rdata = MEMW;
    #22;
    // R9 reset state
    check("R9 result_q in reset", result_q, 32'h0);
    check("R9 misal_q in reset", {31'h0, misal_q}, 32'h0);
    check("R9 vld_q in reset", {31'h0, vld_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      en   = 1'b1;
      kind = VECS[i].kind;
      base = VECS[i].base;
      imm  = VECS[i].imm;
      #1;
      check($sformatf("R1 addr vec %0d", i), addr, VECS[i].e_addr);
      check($sformatf("R7 rd_en vec %0d", i), {31'h0, rd_en}, {31'h0, VECS[i].e_rd});
      @(negedge clk);
      en = 1'b0;
      #1;
      check($sformatf("R2-R8 result vec %0d", i), result_q, VECS[i].e_res);
      check($sformatf("R6 misal vec %0d", i), {31'h0, misal_q}, {31'h0, VECS[i].e_mis});
      check($sformatf("R7 vld vec %0d", i), {31'h0, vld_q}, 32'h1);
    end

    // R7: load a value, then idle with changed inputs; result must hold
    @(negedge clk);
    en = 1'b1; kind = 3'd4; base = 32'h40; imm = 16'h0; rdata = 32'h1234_5678;
    @(negedge clk);
    en = 1'b0; kind = 3'd0; base = 32'h41; rdata = 32'hAAAA_AAAA;
    #1;
    check("R7 rd_en low when idle", {31'h0, rd_en}, 32'h0);
    @(negedge clk);
    #1;
    check("R7 result holds while idle", result_q, 32'h1234_5678);
    check("R7 vld drops while idle", {31'h0, vld_q}, 32'h0);

    // R8 reserved code 7 after a nonzero result
    @(negedge clk);
    en = 1'b1; kind = 3'd7; base = 32'h0; imm = 16'h0;
    #1;
    check("R8 kind 7 no read", {31'h0, rd_en}, 32'h0);
    @(negedge clk);
    en = 1'b0;
    #1;
    check("R8 kind 7 result zero", result_q, 32'h0);
    check("R8 kind 7 no misal", {31'h0, misal_q}, 32'h0);

    // R9 reset in the middle of a run clears registered outputs
    en = 1'b1; kind = 3'd4; base = 32'h0; rdata = MEMW;
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R9 mid-run reset result", result_q, 32'h0);
    check("R9 mid-run reset vld", {31'h0, vld_q}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule